// File: doc/BRIEF.md
# MDIO Management Master

This block is a host-controlled master for the two-wire PHY management bus in its Clause 22 form. A host configures it through two 32-bit registers. The control register holds an enable flag and an 8-bit clock divider, and it reports whether the block is idle. The access register holds one complete management transaction: a go/busy flag, a direction flag, a PHY address, a register address and 16 data bits. Writing the access register with the go flag set starts a transaction. The host then polls the same flag until it reads back zero.

During a transaction the block produces the management clock by dividing the system clock. It shifts out the frame, most significant bit first: a preamble, the start and opcode fields, both addresses, the turnaround and the data. For a read it releases the data line from the turnaround onward and captures the 16 bits that the PHY returns. Those bits then replace the data field of the access register. The management clock runs at the system clock divided by 2·(div+1). Software picks div as the system clock frequency over 2.2 MHz, minus one.

Top module: `mdio_master`

## Requirements
- R1: After reset, both register read buses are zero, the management clock is low and the data-line output enable is low.
- R2: The control register reads back the enable at bit 30 and the divider at bits 7:0. Bit 31 (idle) reads 1 only while enabled with no transaction in progress; it reads 0 while a transaction runs or while disabled.
- R3: An access-register write with bit 31 set, made while enabled and idle, starts a transaction. Bit 31 then reads 1 for exactly 128·(div+1) system clocks, counted from the write edge.
- R4: The management clock idles low. Its first rising edge comes div+1 clocks after the start edge, and consecutive rising edges are 2·(div+1) clocks apart.
- R5: The frame holds 64 bits, sampled on rising clock edges, MSB first. In order: 32 ones, start 01, opcode (01 write, 10 read), the 5-bit PHY address, the 5-bit register address, turnaround 10 on a write, then 16 data bits. The data line changes only on falling clock edges.
- R6: On a read, the output enable is low for frame bits 46 to 63. The block samples the input on the rising edges of bits 48 to 63, and the 16 bits then appear at access bits 15:0 once bit 31 clears.
- R7: An access-register write made while bit 31 is set is ignored. The stored fields and the frame in flight are unchanged.
- R8: A go write while disabled starts nothing. Bit 31 stays 0 and the management clock stays low.
- R9: The access register reads back the write flag at bit 30, the register address at bits 25:21, the PHY address at bits 20:16 and the data at bits 15:0. A write with bit 31 clear stores these fields without starting a transaction.
- R10: The output enable is high throughout a write frame and low whenever no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 access |
| regWrData | input | 32 | Register write data |
| ctrlRdData | output | 32 | Control register read value |
| accRdData | output | 32 | Access register read value |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data output |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data input |

## Verification
All results are timed from the edge that takes the go write. The busy flag is sampled on every falling system-clock edge after that write, and its count must equal 128·(div+1). The first rising edge of the management clock is due in the div+2nd sample, and each later rising edge is due 2·(div+1) samples after the one before. The bench records the data line and the output enable at each observed rising edge. It changes its PHY input one sample after each falling edge, so each input bit is stable well before the rising edge that captures it. Readback of the captured data and of the idle bit is checked in the first sample after busy clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Register geometry: these bit positions are decoded by host software.
  localparam int REG_W    = 32;
  localparam int GO_BIT   = 31;
  localparam int WR_BIT   = 30;
  localparam int IDLE_BIT = 31;
  localparam int ENA_BIT  = 30;

  localparam logic SEL_CTRL   = 1'b0;
  localparam logic SEL_ACCESS = 1'b1;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic active;    // transaction in progress
    logic load;      // capture a new frame
    logic shiftOut;  // falling management clock edge, advance frame
    logic sampleIn;  // rising management clock edge, sample input
    logic finish;    // last falling edge, transaction ends
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int FRAME_LEN = 64,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrite,
  input  logic             accWrite,
  input  logic             goBit,
  input  logic             enaIn,
  input  logic [DIV_W-1:0] divIn,
  output logic             enable,
  output logic [DIV_W-1:0] divider,
  output logic             mdc,
  output mdioStrb_t        strb,
  output logic [IDX_W-1:0] bitIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             enableQ;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divLatch;
  logic [DIV_W-1:0] divCnt;
  logic             runQ;
  logic             mdcQ;
  logic [IDX_W-1:0] bitCnt;
  logic             goReq;
  logic             tick;

  assign goReq = accWrite && goBit && enableQ && !runQ;
  assign tick  = runQ && (divCnt == divLatch);

  always_comb begin
    strb.active   = runQ;
    strb.load     = goReq;
    strb.sampleIn = tick && !mdcQ;
    strb.shiftOut = tick && mdcQ && (bitCnt != LAST_IDX);
    strb.finish   = tick && mdcQ && (bitCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      divQ     <= '0;
      divLatch <= '0;
      divCnt   <= '0;
      runQ     <= 1'b0;
      mdcQ     <= 1'b0;
      bitCnt   <= '0;
    end else begin
      if (ctrlWrite) begin
        enableQ <= enaIn;
        divQ    <= divIn;
      end
      if (goReq) begin
        runQ     <= 1'b1;
        divLatch <= divQ;
        divCnt   <= '0;
        mdcQ     <= 1'b0;
        bitCnt   <= '0;
      end else if (runQ) begin
        if (tick) begin
          divCnt <= '0;
          mdcQ   <= !mdcQ;
          if (mdcQ) begin
            if (bitCnt == LAST_IDX) runQ <= 1'b0;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign enable  = enableQ;
  assign divider = divQ;
  assign mdc     = mdcQ;
  assign bitIdx  = bitCnt;

  // R4: clock rests low outside a transaction
  a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !mdcQ);
  // R4: clock level holds between divider terminal counts
  a_r4_mdc_hold: assert property (@(posedge clk) disable iff (!rstN)
    runQ && $past(runQ) && (divCnt != '0) |-> $stable(mdcQ));
  // R8: a transaction only starts from the enabled state
  a_r8_start_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> $past(enableQ));
  // R3: busy ends only after the last frame bit
  a_r3_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> ($past(bitCnt) == LAST_IDX));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W,
  localparam int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrb_t         strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              accWrite,
  input  logic              wrIn,
  input  logic [ADDR_W-1:0] phyIn,
  input  logic [ADDR_W-1:0] regIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              wrFlag,
  output logic [ADDR_W-1:0] phyAddr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] dataVal
);
  localparam int TA_IDX   = FRAME_LEN - DATA_W - 2;
  localparam int DATA_IDX = FRAME_LEN - DATA_W;

  logic [FRAME_LEN-1:0] frameQ;
  logic [FRAME_LEN-1:0] nextFrame;
  logic                 isReadQ;
  logic                 wrFlagQ;
  logic [ADDR_W-1:0]    phyQ;
  logic [ADDR_W-1:0]    regQ;
  logic [DATA_W-1:0]    dataQ;
  logic [DATA_W-1:0]    rdShiftQ;

  always_comb begin
    nextFrame = {{PRE_LEN{1'b1}}, 2'b01, (wrIn ? 2'b01 : 2'b10),
                 phyIn, regIn, 2'b10,
                 (wrIn ? dataIn : {DATA_W{1'b1}})};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ   <= '0;
      isReadQ  <= 1'b0;
      wrFlagQ  <= 1'b0;
      phyQ     <= '0;
      regQ     <= '0;
      dataQ    <= '0;
      rdShiftQ <= '0;
    end else begin
      if (strb.load) begin
        frameQ   <= nextFrame;
        isReadQ  <= !wrIn;
        rdShiftQ <= '0;
      end else if (strb.shiftOut) begin
        frameQ <= {frameQ[FRAME_LEN-2:0], 1'b1};
      end
      if (accWrite && !strb.active) begin
        wrFlagQ <= wrIn;
        phyQ    <= phyIn;
        regQ    <= regIn;
        dataQ   <= dataIn;
      end
      if (strb.sampleIn && (bitIdx >= IDX_W'(DATA_IDX))) begin
        rdShiftQ <= {rdShiftQ[DATA_W-2:0], mdioIn};
      end
      if (strb.finish && isReadQ) begin
        dataQ <= rdShiftQ;
      end
    end
  end

  assign mdioOut = frameQ[FRAME_LEN-1];
  assign mdioOe  = strb.active && !(isReadQ && (bitIdx >= IDX_W'(TA_IDX)));
  assign wrFlag  = wrFlagQ;
  assign phyAddr = phyQ;
  assign regAddr = regQ;
  assign dataVal = dataQ;

  // R7: stored fields are frozen while a transaction runs
  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strb.active && $past(strb.active) |->
      $stable(phyQ) && $stable(regQ) && $stable(wrFlagQ) && $stable(dataQ));
  // R5: the driven bit moves only on a falling management clock edge
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    strb.active && $past(strb.active) && !$past(strb.shiftOut) |->
      $stable(frameQ[FRAME_LEN-1]));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] ctrlRdData,
  output logic [REG_W-1:0] accRdData,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int PHY_LSB   = DATA_W;
  localparam int REGA_LSB  = DATA_W + ADDR_W;
  localparam int ACC_PAD   = REG_W - 2 - 2 * ADDR_W - DATA_W;
  localparam int CTL_PAD   = REG_W - 2 - DIV_W;

  logic              ctrlWrite;
  logic              accWrite;
  logic              enable;
  logic [DIV_W-1:0]  divider;
  mdioStrb_t         strb;
  logic [IDX_W-1:0]  bitIdx;
  logic              wrFlag;
  logic [ADDR_W-1:0] phyAddr;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] dataVal;
  logic              unusedBits;

  assign ctrlWrite  = regWrEn && (regSel == SEL_CTRL);
  assign accWrite   = regWrEn && (regSel == SEL_ACCESS);
  assign unusedBits = ^regWrData;

  mdio_ctrl #(.DIV_W(DIV_W), .FRAME_LEN(FRAME_LEN)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrite (ctrlWrite),
    .accWrite  (accWrite),
    .goBit     (regWrData[GO_BIT]),
    .enaIn     (regWrData[ENA_BIT]),
    .divIn     (regWrData[DIV_W-1:0]),
    .enable    (enable),
    .divider   (divider),
    .mdc       (mdc),
    .strb      (strb),
    .bitIdx    (bitIdx)
  );

  mdio_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .accWrite (accWrite),
    .wrIn     (regWrData[WR_BIT]),
    .phyIn    (regWrData[PHY_LSB +: ADDR_W]),
    .regIn    (regWrData[REGA_LSB +: ADDR_W]),
    .dataIn   (regWrData[DATA_W-1:0]),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .wrFlag   (wrFlag),
    .phyAddr  (phyAddr),
    .regAddr  (regAddr),
    .dataVal  (dataVal)
  );

  assign ctrlRdData = {enable && !strb.active, enable, {CTL_PAD{1'b0}}, divider};
  assign accRdData  = {strb.active, wrFlag, {ACC_PAD{1'b0}}, regAddr, phyAddr, dataVal};
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] ctrlRdData;
  logic [31:0] accRdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = !clk;

  mdio_master i_mdio_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ctrlRdData(ctrlRdData), .accRdData(accRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [63:0] expFrame(input bit wr, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [63:0] expOe(input bit wr);
    return wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
  endfunction

  task automatic runTxn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wdat, input logic [15:0] rdat,
                        input int div, input bit midWrite);
    logic [63:0] bits = '0;
    logic [63:0] oes = '0;
    logic [63:0] mask;
    int busyCnt = 0, rises = 0, lastRise = 0, firstRise = 0;
    int gapErr = 0, chgErr = 0;
    logic prevMdc = 1'b0, prevOut = 1'b0, prevOe = 1'b0;
    regWrite(1'b0, {1'b0, 1'b1, 22'd0, 8'(div)});
    mdioIn = 1'b1;
    regWrite(1'b1, {1'b1, wr, 4'b0, rg, phy, wdat});
    while (accRdData[31] === 1'b1) begin
      busyCnt++;
      if (mdc && !prevMdc) begin
        if (rises == 0) firstRise = busyCnt;
        else if (busyCnt - lastRise != 2 * (div + 1)) gapErr++;
        lastRise = busyCnt;
        bits[63 - rises] = mdioOut;
        oes[63 - rises] = mdioOe;
        rises++;
      end
      if (!mdc && prevMdc) mdioIn = (rises >= 48) ? rdat[63 - rises] : 1'b1;
      if (busyCnt > 1 && mdioOe && prevOe && mdioOut !== prevOut && !(prevMdc && !mdc))
        chgErr++;
      if (busyCnt == 5) chk("R2", "idle bit while busy", 64'(ctrlRdData[31]), 64'd0);
      if (midWrite && busyCnt == 20) begin
        regWrEn = 1'b1; regSel = 1'b1;
        regWrData = {1'b1, !wr, 4'b0, ~rg, ~phy, ~wdat};
      end
      if (midWrite && busyCnt == 21) regWrEn = 1'b0;
      if (midWrite && busyCnt == 23)
        chk("R7", "fields after ignored write", 64'(accRdData[30:0]),
            64'({wr, 4'b0, rg, phy, wdat}));
      prevMdc = mdc; prevOut = mdioOut; prevOe = mdioOe;
      @(negedge clk);
    end
    mask = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    chk("R3", "busy duration", 64'(busyCnt), 64'(128 * (div + 1)));
    chk("R4", "first rise", 64'(firstRise), 64'(div + 2));
    chk("R4", "rise gap errors", 64'(gapErr), 64'd0);
    chk("R5", "rise count", 64'(rises), 64'd64);
    chk("R5", "frame bits", bits & mask, expFrame(wr, phy, rg, wdat) & mask);
    chk("R5", "mdio change off falling edge", 64'(chgErr), 64'd0);
    chk(wr ? "R10" : "R6", "output enable pattern", oes, expOe(wr));
    chk(wr ? "R9" : "R6", "access readback", 64'(accRdData),
        64'({1'b0, wr, 4'b0, rg, phy, (wr ? wdat : rdat)}));
    chk("R2", "idle after finish", 64'(ctrlRdData[31]), 64'd1);
    chk("R10", "idle mdc/oe", 64'({mdc, mdioOe}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int seedDummy;
    int err;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk("R1", "control after reset", 64'(ctrlRdData), 64'd0);
    chk("R1", "access after reset", 64'(accRdData), 64'd0);
    chk("R1", "pins after reset", 64'({mdc, mdioOe}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    regWrite(1'b0, {1'b0, 1'b1, 22'd0, 8'd3});
    chk("R2", "control readback enabled", 64'(ctrlRdData), 64'({1'b1, 1'b1, 22'd0, 8'd3}));

    regWrite(1'b0, {1'b0, 1'b0, 22'd0, 8'd2});
    chk("R2", "control readback disabled", 64'(ctrlRdData), 64'({1'b0, 1'b0, 22'd0, 8'd2}));
    regWrite(1'b1, {1'b1, 1'b1, 4'b0, 5'h03, 5'h04, 16'h1234});
    err = 0;
    for (int i = 0; i < 12; i++) begin
      if (accRdData[31] !== 1'b0 || mdc !== 1'b0) err++;
      @(negedge clk);
    end
    chk("R8", "go while disabled", 64'(err), 64'd0);

    regWrite(1'b1, {1'b0, 1'b1, 4'b0, 5'h0A, 5'h11, 16'hBEEF});
    chk("R9", "fields without go", 64'(accRdData),
        64'({1'b0, 1'b1, 4'b0, 5'h0A, 5'h11, 16'hBEEF}));
    chk("R9", "no start without go", 64'(mdc), 64'd0);

    runTxn(1'b1, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, 0, 1'b0);
    runTxn(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h8001, 0, 1'b0);
    runTxn(1'b1, 5'h15, 5'h0A, 16'hFFFF, 16'h0000, 255, 1'b0);
    runTxn(1'b0, 5'h07, 5'h12, 16'h0000, 16'h5A5A, 2, 1'b1);
    runTxn(1'b1, 5'h09, 5'h02, 16'h0F0F, 16'h0000, 1, 1'b1);

    for (int t = 0; t < 12; t++) begin
      runTxn(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom),
             16'($urandom), 16'($urandom), int'($urandom_range(0, 5)), 1'b0);
    end

    summary();
    $finish;
  end
endmodule